// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block sits in the transmit path between a byte-wide frame source and a 10/100 MAC transmitter. The source delivers a frame as a stream of bytes: destination address, source address field, type/length and payload, with the final byte flagged. The formatter can put the station's own address into the source address position, extend short frames with zero bytes, and append a 32-bit frame check sequence. The result leaves as a byte stream with valid/ready/last handshaking.

There are four option inputs. Source-address handling has two of them. With substitution enabled and overwrite set, the six bytes that follow the destination address are replaced in place. With substitution enabled and overwrite clear, the source is expected to omit its source address, and the block inserts six station bytes after the destination address. With substitution disabled, the overwrite input has no effect. Padding and the FCS are each switched on their own. All four options are captured with the first byte of a frame and hold for the rest of that frame. The block emits preamble, gap timing and line signalling to nothing; it only shapes the byte stream. While it generates bytes itself, it holds off the source.

Top module: `tx_frame_fmt`

## Requirements
- R1: After reset, with no input offered, outValid is low, and the first frame's FCS starts from a fresh all-ones CRC state.
- R2: With all four options off, every input byte appears unchanged on the output in order, and outLast is high exactly with the byte that carried inLast.
- R3: With substitution and overwrite both on, output bytes 6 to 11 (counting from 0) are the station address, most significant byte (stationAddr[47:40]) first. All other bytes pass unchanged, and the frame length is unchanged.
- R4: With substitution on and overwrite off, a frame of at least 7 input bytes gets the six station address bytes (most significant first) inserted after input byte 5, so the output grows by six bytes.
- R5: With substitution off, the overwrite option has no effect on the output.
- R6: With padding on, a frame shorter than 60 bytes, after address handling, is extended with 0x00 bytes to exactly 60 bytes before any FCS. Frames of 60 bytes or more, and any frame with padding off, get no pad.
- R7: With the FCS option on, four bytes follow the frame (and pad). They are the CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, final inversion) over every preceding output byte of the frame, sent least significant byte first. A 1518-byte input frame leaves as 1522 bytes.
- R8: While station, pad or FCS bytes are being generated, inReady is low. inReady is never high while outReady is low. Each input byte is consumed exactly once.
- R9: Option inputs are taken with the first byte of a frame. Changing them later in the frame has no effect on that frame.
- R10: While outValid is high and outReady is low, outValid, outData and outLast hold until the byte is taken (given a source that holds its byte).
- R11: outLast is high only on the final byte of each output frame. Frames presented back-to-back come out as separate, correctly formatted frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stationAddr | input | 48 | Station address, bits 47:40 sent first |
| optSaIns | input | 1 | Source-address substitution enable |
| optSaOvr | input | 1 | Overwrite in place (1) or insert (0); used only when substitution is on |
| optPad | input | 1 | Pad short frames to 60 bytes |
| optFcs | input | 1 | Append CRC-32 FCS |
| inData | input | 8 | Input frame byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Input byte is the last of its frame |
| inReady | output | 1 | Block accepts the input byte this cycle |
| outData | output | 8 | Output frame byte |
| outValid | output | 1 | Output byte valid |
| outLast | output | 1 | Output byte is the last of its frame |
| outReady | input | 1 | Downstream accepts the output byte |

## Verification
The hardest situation to reach from the ports is a new frame's first byte waiting at the input while the previous frame is still in its pad or FCS phase, with downstream stalls landing in the middle of generated bytes. The test gets there by sending frames back-to-back with no gap, under a randomly throttled outReady. Any byte wrongly taken during generation then shows up as corruption in the output stream. A directed frame also flips every option right after its first byte is taken, so it can be seen that options are held for the whole frame.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int FCS_BYTES  = 4;
  localparam int IDX_W      = $clog2(ADDR_BYTES);
  localparam int FIDX_W     = $clog2(FCS_BYTES);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [1:0] {
    SEL_PASS,
    SEL_STATION,
    SEL_ZERO,
    SEL_FCS
  } byteSel_e;

  typedef struct packed {
    logic insEn;
    logic ovrEn;
    logic padEn;
    logic fcsEn;
  } txOpts_t;

  typedef struct packed {
    byteSel_e          sel;
    logic [IDX_W-1:0]  stIdx;
    logic [FIDX_W-1:0] fcsIdx;
    logic              crcStep;
    logic              crcClear;
  } fmtStrobe_t;

  // one byte of a reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tx_fmt_ctrl.sv
module tx_fmt_ctrl
  import tx_fmt_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  txOpts_t    liveOpts,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  input  logic       outReady,
  output fmtStrobe_t stb
);

  localparam logic [CNT_W-1:0]  DA_END  = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0]  SA_LO   = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0]  SA_HI   = CNT_W'(2 * ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0]  PAD_END = CNT_W'(MIN_LEN - 1);
  localparam logic [FIDX_W-1:0] FCS_END = FIDX_W'(FCS_BYTES - 1);

  typedef enum logic [1:0] {ST_DATA, ST_SAINS, ST_PAD, ST_FCS} state_e;

  state_e            state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt, cntInc;
  logic [FIDX_W-1:0] fcsIdx, fcsIdxNxt;
  logic              busy;
  txOpts_t           held, eff;
  logic              insMode, ovrMode, needPad, padDone, inSaWin, go;

  assign eff     = busy ? held : liveOpts;
  assign insMode = eff.insEn && !eff.ovrEn;
  assign ovrMode = eff.insEn && eff.ovrEn;
  assign cntInc  = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
  assign needPad = eff.padEn && (cnt < PAD_END);
  assign padDone = (cnt == PAD_END);
  assign inSaWin = (cnt >= SA_LO) && (cnt <= SA_HI);

  always_comb begin
    stateNxt     = state;
    cntNxt       = cnt;
    fcsIdxNxt    = fcsIdx;
    inReady      = 1'b0;
    outValid     = 1'b0;
    outLast      = 1'b0;
    go           = 1'b0;
    stb.sel      = SEL_PASS;
    stb.stIdx    = IDX_W'(cnt - SA_LO);
    stb.fcsIdx   = fcsIdx;
    case (state)
      ST_DATA: begin
        inReady  = outReady;
        outValid = inValid;
        go       = inValid && outReady;
        if (ovrMode && inSaWin) stb.sel = SEL_STATION;
        outLast = inLast && !needPad && !eff.fcsEn;
        if (go) begin
          cntNxt = cntInc;
          if (inLast) begin
            if (needPad)        stateNxt = ST_PAD;
            else if (eff.fcsEn) stateNxt = ST_FCS;
            else                cntNxt   = '0;
          end else if (insMode && cnt == DA_END) begin
            stateNxt = ST_SAINS;
          end
        end
      end
      ST_SAINS: begin
        outValid = 1'b1;
        go       = outReady;
        stb.sel  = SEL_STATION;
        if (go) begin
          cntNxt = cntInc;
          if (cnt == SA_HI) stateNxt = ST_DATA;
        end
      end
      ST_PAD: begin
        outValid = 1'b1;
        go       = outReady;
        stb.sel  = SEL_ZERO;
        outLast  = padDone && !eff.fcsEn;
        if (go) begin
          cntNxt = cntInc;
          if (padDone) begin
            if (eff.fcsEn) stateNxt = ST_FCS;
            else begin
              stateNxt = ST_DATA;
              cntNxt   = '0;
            end
          end
        end
      end
      default: begin
        outValid = 1'b1;
        go       = outReady;
        stb.sel  = SEL_FCS;
        outLast  = (fcsIdx == FCS_END);
        if (go) begin
          fcsIdxNxt = fcsIdx + 1'b1;
          if (fcsIdx == FCS_END) begin
            stateNxt  = ST_DATA;
            cntNxt    = '0;
            fcsIdxNxt = '0;
          end
        end
      end
    endcase
    stb.crcStep  = go && (state != ST_FCS);
    stb.crcClear = go && outLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_DATA;
      cnt    <= '0;
      fcsIdx <= '0;
      busy   <= 1'b0;
      held   <= '0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      fcsIdx <= fcsIdxNxt;
      if (go) begin
        busy <= !outLast;
        if (!busy) held <= liveOpts;
      end
    end
  end

endmodule

// File: rtl/tx_fmt_dpath.sv
module tx_fmt_dpath
  import tx_fmt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  fmtStrobe_t              stb,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [7:0]              inData,
  output logic [7:0]              outData
);

  logic [31:0] crcReg, crcOut;
  logic [7:0]  stationByte, fcsByte;

  assign crcOut = ~crcReg;

  generate
    if (ADDR_BYTES > 1) begin : g_multi
      always_comb begin
        stationByte = stationAddr[8*ADDR_BYTES-1 -: 8];
        for (int k = 0; k < ADDR_BYTES; k++)
          if (stb.stIdx == IDX_W'(k)) stationByte = stationAddr[8*(ADDR_BYTES-1-k) +: 8];
      end
    end else begin : g_single
      assign stationByte = stationAddr[7:0];
    end
  endgenerate

  always_comb begin
    fcsByte = crcOut[7:0];
    for (int k = 0; k < FCS_BYTES; k++)
      if (stb.fcsIdx == FIDX_W'(k)) fcsByte = crcOut[8*k +: 8];
  end

  always_comb begin
    case (stb.sel)
      SEL_PASS:    outData = inData;
      SEL_STATION: outData = stationByte;
      SEL_ZERO:    outData = 8'h00;
      default:     outData = fcsByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             crcReg <= '1;
    else if (stb.crcClear) crcReg <= '1;
    else if (stb.crcStep)  crcReg <= crcByte(crcReg, outData);
  end

endmodule

// File: rtl/tx_frame_fmt.sv
module tx_frame_fmt
  import tx_fmt_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    optSaIns,
  input  logic                    optSaOvr,
  input  logic                    optPad,
  input  logic                    optFcs,
  input  logic [7:0]              inData,
  input  logic                    inValid,
  input  logic                    inLast,
  output logic                    inReady,
  output logic [7:0]              outData,
  output logic                    outValid,
  output logic                    outLast,
  input  logic                    outReady
);

  txOpts_t    liveOpts;
  fmtStrobe_t stb;

  assign liveOpts = '{insEn: optSaIns, ovrEn: optSaOvr, padEn: optPad, fcsEn: optFcs};

  tx_fmt_ctrl #(.MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .liveOpts (liveOpts),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .outReady (outReady),
    .stb      (stb)
  );

  tx_fmt_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .stationAddr (stationAddr),
    .inData      (inData),
    .outData     (outData)
  );

endmodule

// File: rtl/tx_frame_fmt_chk.sv
module tx_frame_fmt_chk
  import tx_fmt_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input logic       clk,
  input logic       rstN,
  input logic       optPad,
  input logic       optFcs,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outLast,
  input logic       outReady
);

  logic        hs, busyC, heldPad, heldFcs, effPad, effFcs;
  logic [15:0] ocnt;
  int          minNeed;

  assign hs      = outValid && outReady;
  assign effPad  = busyC ? heldPad : optPad;
  assign effFcs  = busyC ? heldFcs : optFcs;
  assign minNeed = effFcs ? MIN_LEN + FCS_BYTES : MIN_LEN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ocnt    <= '0;
      busyC   <= 1'b0;
      heldPad <= 1'b0;
      heldFcs <= 1'b0;
    end else if (hs) begin
      ocnt  <= outLast ? '0 : ((ocnt == '1) ? ocnt : ocnt + 1'b1);
      busyC <= !outLast;
      if (!busyC) begin
        heldPad <= optPad;
        heldFcs <= optFcs;
      end
    end
  end

  // R8: generated bytes (no input behind them) keep the source held off
  a_r8_gen_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !inValid |-> !inReady);

  // R8: input is never taken without room downstream
  a_r8_ready_needs_space: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

  // R10: a stalled byte is held
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  // R6: a padded frame is never shorter than the minimum
  a_r6_min_len: assert property (@(posedge clk) disable iff (!rstN)
    hs && outLast && effPad |-> (32'(ocnt) + 1) >= minNeed);

  // R7: the final FCS byte is generated, not taken from the input
  a_r7_fcs_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    hs && outLast && effFcs |-> !inReady);

endmodule

bind tx_frame_fmt tx_frame_fmt_chk #(.MIN_LEN(MIN_LEN)) u_chk (.*);

// File: tb/test_tx_frame_fmt.sv
module test_tx_frame_fmt;

  localparam int MIN_LEN = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] stationAddr = 48'h02A1B2C3D4E5;
  logic        optSaIns = 1'b0, optSaOvr = 1'b0, optPad = 1'b0, optFcs = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inValid = 1'b0, inLast = 1'b0, inReady;
  logic [7:0]  outData;
  logic        outValid, outLast;
  logic        outReady = 1'b1;

  int tests = 0, fails = 0;
  int gotFrames = 0, inTaken = 0;
  bit randReady = 1'b0, done = 1'b0;
  logic [7:0] inQ[$];
  bit         lastQ[$];
  logic [7:0] expQ[$];
  logic [7:0] gotQ[$];
  bit         prevStall = 1'b0, prevLast = 1'b0;
  logic [7:0] prevData = 8'h00;

  always #4 clk = ~clk;

  tx_frame_fmt i_tx_frame_fmt (
    .clk(clk), .rstN(rstN), .stationAddr(stationAddr),
    .optSaIns(optSaIns), .optSaOvr(optSaOvr), .optPad(optPad), .optFcs(optFcs),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outReady(outReady)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] saByte(input int k);
    return stationAddr[8*(5-k) +: 8];
  endfunction

  // expected output of one frame, appended to expQ, from the requirements
  task automatic addFrame(input int len);
    logic [7:0] f[$];
    logic [7:0] o[$];
    logic [31:0] c;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      f.push_back(b);
      inQ.push_back(b);
      lastQ.push_back(i == len - 1);
    end
    for (int i = 0; i < len; i++) begin
      if (optSaIns && !optSaOvr && i == 6)
        for (int k = 0; k < 6; k++) o.push_back(saByte(k));
      if (optSaIns && optSaOvr && i >= 6 && i < 12) o.push_back(saByte(i - 6));
      else o.push_back(f[i]);
    end
    if (optPad) while (o.size() < MIN_LEN) o.push_back(8'h00);
    if (optFcs) begin
      c = 32'hFFFFFFFF;
      foreach (o[j])
        for (int b = 0; b < 8; b++)
          c = (c[0] ^ o[j][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      c = ~c;
      for (int k = 0; k < 4; k++) o.push_back(c[8*k +: 8]);
    end
    foreach (o[j]) expQ.push_back(o[j]);
  endtask

  task automatic driveAll(input int gapMax);
    while (inQ.size() > 0) begin
      int g;
      g = (gapMax > 0) ? $urandom_range(gapMax, 0) : 0;
      repeat (g) begin @(posedge clk); #2; end
      inData  = inQ.pop_front();
      inLast  = lastQ.pop_front();
      inValid = 1'b1;
      do @(negedge clk); while (!inReady);
      @(posedge clk); #2;
      inValid = 1'b0;
      inLast  = 1'b0;
    end
  endtask

  task automatic runBatch(input string tag, input int nFrames, input int gapMax, input bit flip);
    int target, inExp, in0, bad;
    target = gotFrames + nFrames;
    inExp  = inQ.size();
    in0    = inTaken;
    gotQ.delete();
    fork
      driveAll(gapMax);
      if (flip) begin
        while (inTaken == in0) @(negedge clk);
        @(posedge clk); #2;
        optSaIns = ~optSaIns; optSaOvr = ~optSaOvr; optPad = ~optPad; optFcs = ~optFcs;
      end
    join
    while (gotFrames < target) @(negedge clk);
    @(posedge clk); #2;
    check(gotQ.size() == expQ.size(), tag, "output length", gotQ.size(), expQ.size());
    bad = -1;
    for (int j = 0; j < gotQ.size() && j < expQ.size(); j++)
      if (bad < 0 && gotQ[j] !== expQ[j]) bad = j;
    if (bad >= 0) check(1'b0, tag, $sformatf("byte %0d", bad), gotQ[bad], expQ[bad]);
    else          check(1'b1, tag, "bytes", 0, 0);
    check(inTaken - in0 == inExp, "R8", "input bytes consumed", inTaken - in0, inExp);
    expQ.delete();
  endtask

  task automatic setOpts(input bit ins, input bit ovr, input bit pad, input bit fcs);
    optSaIns = ins; optSaOvr = ovr; optPad = pad; optFcs = fcs;
  endtask

  // monitor, half a cycle after the inputs change
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(outValid && outData == prevData && outLast == prevLast, "R10", "stalled byte held",
              {outValid, outLast, outData}, {1'b1, prevLast, prevData});
      prevStall = outValid && !outReady;
      prevData  = outData;
      prevLast  = outLast;
      if (outValid && outReady) begin
        gotQ.push_back(outData);
        if (outLast) gotFrames++;
      end
      if (inValid && inReady) inTaken++;
    end else begin
      prevStall = 1'b0;
    end
  end

  initial forever begin
    @(posedge clk); #2;
    outReady = randReady ? ($urandom_range(3, 0) != 0) : 1'b1;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    @(posedge clk); #2;

    setOpts(0, 1, 0, 1); addFrame(20);  runBatch("R1 first FCS", 1, 0, 0);
    setOpts(0, 0, 0, 0); addFrame(25);  runBatch("R2 pass-through", 1, 2, 0);
    addFrame(1);                        runBatch("R2 single byte", 1, 0, 0);
    setOpts(1, 1, 0, 0); addFrame(40);  runBatch("R3 overwrite", 1, 1, 0);
    setOpts(1, 0, 0, 0); addFrame(40);  runBatch("R4 insert", 1, 1, 0);
    addFrame(6);                        runBatch("R4 header-only no insert", 1, 0, 0);
    setOpts(0, 1, 0, 0); addFrame(40);  runBatch("R5 overwrite ignored", 1, 0, 0);
    setOpts(0, 0, 1, 0); addFrame(10);  runBatch("R6 pad short", 1, 0, 0);
    addFrame(59);                       runBatch("R6 pad 59", 1, 0, 0);
    addFrame(60);                       runBatch("R6 no pad at 60", 1, 0, 0);
    setOpts(1, 0, 1, 0); addFrame(20);  runBatch("R6 insert then pad", 1, 0, 0);
    setOpts(0, 0, 0, 1); addFrame(100); runBatch("R7 fcs only", 1, 0, 0);
    setOpts(0, 0, 1, 1); addFrame(1);   runBatch("R7 pad and fcs on one byte", 1, 0, 0);
    setOpts(1, 1, 0, 1); addFrame(1518);
    runBatch("R7 max tagged length", 1, 0, 0);
    randReady = 1'b1;
    setOpts(1, 0, 1, 1); addFrame(8); addFrame(30); addFrame(70);
    runBatch("R11 back-to-back", 3, 0, 0);
    setOpts(1, 1, 1, 1); addFrame(30);  runBatch("R9 options flipped mid-frame", 1, 0, 1);
    setOpts(0, 0, 0, 0); addFrame(45);  runBatch("R10 stalls", 1, 0, 0);

    for (int t = 0; t < 30; t++) begin
      int nf;
      setOpts($urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0));
      randReady = $urandom_range(1, 0);
      nf = $urandom_range(3, 1);
      for (int f = 0; f < nf; f++) addFrame($urandom_range(200, 1));
      runBatch($sformatf("RAND %0d", t), nf, $urandom_range(3, 0), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule